// File: doc/BRIEF.md
# Command Packet Parser and Acknowledger

This block sits behind a byte-wide serial receiver and turns its byte stream into command packets. A packet opens with a four-byte length field, least-significant byte first. The length counts every byte after the header. The first two counted bytes are a command code and a sub-command code, and any payload follows them. The parser consumes exactly the declared number of bytes and then treats the next byte as the start of a new header. A malformed packet therefore costs only its own bytes and never shifts the framing of the packets after it.

The supported pairs are: an identify request; a bitstream-list clear; and three measurement commands. The measurement commands store a setup record, start the stored measurements, or clear them. The setup record carries an id, a parallel/serial mode, a readout count, an evaluation-time selector, a heatup count and a cooldown cycle count. These values are committed to output registers only when the whole packet is judged valid. Start and clear requests leave as single-cycle pulses. Every packet is answered on a byte output with a valid/ready handshake. The answer is three bytes: the command, the sub-command, and a success or failure status. No new input byte is accepted until the answer has been fully taken.

Top module: `cmd_packet_parser`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0, all pulse outputs are 0 and every stored setup field is 0.
- R2: The header is 4 bytes, least-significant byte first, giving the count of bytes that follow it. After exactly that many bytes, the next byte accepted is the first header byte of a new packet.
- R3: Each packet is answered with exactly 3 bytes: the command byte, the sub-command byte, and a status of 0x06 (success) or 0x15 (failure). While the answer is pending, in_ready is 0. The answer byte on out_data holds steady while out_ready is 0.
- R4: Command 0x01 with any sub-command and a length of 2 is answered with status 0x06.
- R5: Command 0x04 with sub-command 0x01 and a length of 21 stores its 19 payload bytes on success. Payload offsets 0–1 are the id, 2 is the mode, 3–6 the readout count, 7–10 the evaluation-time selector, 11–14 the heatup count and 15–18 the cooldown count. All multi-byte fields are least-significant byte first. The stored fields change together when the first answer byte appears.
- R6: Command 0x04 with sub-command 0x03 and a length of 2 raises start_pulse for exactly one cycle, in the cycle where the first answer byte is first presented.
- R7: Command 0x04 with sub-command 0xF0 raises meas_clear_pulse for one cycle. Command 0x03 with sub-command 0xF0 raises list_clear_pulse for one cycle. Both use length 2 and are answered with 0x06.
- R8: Any other command or sub-command pair, including command 0x02 and pair 0x03/0x01, is answered with 0x15. Its payload is discarded, and no field or pulse changes.
- R9: A supported pair whose length differs from its expected size (21 for 0x04/0x01, otherwise 2) is answered with 0x15. All declared bytes are still consumed, and no field or pulse changes.
- R10: A packet of length 0 is answered with 0x00, 0x00, 0x15. A packet of length 1 is answered with its command byte, 0x00, 0x15.
- R11: The mode byte value 0x01 sets meas_parallel to 1 and 0x00 sets it to 0. Any other mode value fails the whole packet with 0x15 and leaves the stored fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte is valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Parser accepts a byte this cycle |
| out_valid | output | 1 | Answer byte is valid |
| out_data | output | 8 | Answer byte |
| out_ready | input | 1 | Consumer takes the answer byte |
| meas_id | output | 16 | Stored measurement id |
| meas_parallel | output | 1 | Stored mode: 1 parallel, 0 serial |
| meas_readouts | output | 32 | Stored readout count |
| meas_eval_sel | output | 32 | Stored evaluation-time selector |
| meas_heatup | output | 32 | Stored heatup count |
| meas_cooldown | output | 32 | Stored cooldown cycle count |
| start_pulse | output | 1 | One-cycle start request |
| meas_clear_pulse | output | 1 | One-cycle stored-measurement clear request |
| list_clear_pulse | output | 1 | One-cycle bitstream-list clear request |

## Verification
The hardest case to reach is a header whose length is large and non-zero in its upper bytes. Such a packet checks two things together: that the length is assembled least-significant byte first, and that the declared count is still honoured when the packet fails. The stimulus sends a 0x04/0x03 packet that declares 258 bytes and supplies 256 bytes of filler. The packet must end in a failure answer with no start pulse. If the bytes were taken in the wrong order, the declared count would be enormous and the answer would never come. An identify packet sent right after it confirms that the framing has returned to the header.

// File: rtl/cpp_pkg.sv
package cpp_pkg;

  localparam logic [7:0] CMD_IDENT   = 8'h01;
  localparam logic [7:0] CMD_BITLIST = 8'h03;
  localparam logic [7:0] CMD_MEAS    = 8'h04;

  localparam logic [7:0] SUB_STORE   = 8'h01;
  localparam logic [7:0] SUB_START   = 8'h03;
  localparam logic [7:0] SUB_CLEAR   = 8'hF0;

  localparam logic [7:0] ST_ACK      = 8'h06;
  localparam logic [7:0] ST_NACK     = 8'h15;

  localparam int PAYLOAD_BYTES = 19;
  localparam int BARE_LEN      = 2;
  localparam int STORE_LEN     = BARE_LEN + PAYLOAD_BYTES;
  localparam int REPLY_BYTES   = 3;

  typedef enum logic [1:0] {
    FR_HDR   = 2'd0,
    FR_BODY  = 2'd1,
    FR_REPLY = 2'd2
  } fr_state_t;

  typedef enum logic [2:0] {
    ACT_NONE  = 3'd0,
    ACT_IDENT = 3'd1,
    ACT_STORE = 3'd2,
    ACT_START = 3'd3,
    ACT_MCLR  = 3'd4,
    ACT_LCLR  = 3'd5
  } act_t;

  typedef struct packed {
    logic [15:0] id;
    logic        parallel;
    logic [31:0] readouts;
    logic [31:0] eval_sel;
    logic [31:0] heatup;
    logic [31:0] cooldown;
  } meas_cfg_t;

endpackage

// File: rtl/cpp_framer.sv
module cpp_framer
  import cpp_pkg::*;
#(
  parameter int HDR_BYTES = 4,
  localparam int LEN_W = 8 * HDR_BYTES,
  localparam int CNT_W = (HDR_BYTES > 1) ? $clog2(HDR_BYTES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  input  logic             reply_done,
  output logic             byte_stb,
  output logic [LEN_W-1:0] body_idx,
  output logic [LEN_W-1:0] pkt_len,
  output logic             pkt_end
);

  fr_state_t        st_q, st_d;
  logic [CNT_W-1:0] hcnt_q, hcnt_d;
  logic [LEN_W-1:0] len_q, len_d, len_shift;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic [LEN_W-1:0] idx_q, idx_d;
  logic             accept, hdr_last;

  assign in_ready  = (st_q != FR_REPLY);
  assign accept    = in_valid && in_ready;
  assign len_shift = {in_data, len_q[LEN_W-1:8]};
  assign hdr_last  = (st_q == FR_HDR) && accept && (hcnt_q == CNT_W'(HDR_BYTES - 1));
  assign byte_stb  = (st_q == FR_BODY) && accept;
  assign pkt_end   = (hdr_last && (len_shift == '0)) ||
                     (byte_stb && (rem_q == LEN_W'(1)));
  assign body_idx  = idx_q;
  assign pkt_len   = len_q;

  always_comb begin
    st_d   = st_q;
    hcnt_d = hcnt_q;
    len_d  = len_q;
    rem_d  = rem_q;
    idx_d  = idx_q;
    unique case (st_q)
      FR_HDR: begin
        if (accept) begin
          len_d  = len_shift;
          hcnt_d = hcnt_q + CNT_W'(1);
          if (hdr_last) begin
            hcnt_d = '0;
            rem_d  = len_shift;
            idx_d  = '0;
            st_d   = (len_shift == '0) ? FR_REPLY : FR_BODY;
          end
        end
      end
      FR_BODY: begin
        if (accept) begin
          rem_d = rem_q - LEN_W'(1);
          idx_d = idx_q + LEN_W'(1);
          if (rem_q == LEN_W'(1)) st_d = FR_REPLY;
        end
      end
      FR_REPLY: begin
        if (reply_done) st_d = FR_HDR;
      end
      default: st_d = FR_HDR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= FR_HDR;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      len_q  <= '0;
    end else if (st_q == FR_HDR && accept) begin
      hcnt_q <= hcnt_d;
      len_q  <= len_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      idx_q <= '0;
    end else if (accept) begin
      rem_q <= rem_d;
      idx_q <= idx_d;
    end
  end

endmodule

// File: rtl/cpp_decoder.sv
module cpp_decoder
  import cpp_pkg::*;
#(
  parameter int HDR_BYTES = 4,
  localparam int LEN_W = 8 * HDR_BYTES
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       byte_stb,
  input  logic [LEN_W-1:0]           body_idx,
  input  logic [7:0]                 in_data,
  input  logic                       pkt_end,
  input  logic [LEN_W-1:0]           pkt_len,
  output logic                       rsp_load,
  output logic [REPLY_BYTES-1:0][7:0] rsp_bytes,
  output meas_cfg_t                  cfg,
  output logic                       start_pulse,
  output logic                       meas_clear_pulse,
  output logic                       list_clear_pulse
);

  logic [7:0] cmd_q, sub_q;
  logic [7:0] pay_q [PAYLOAD_BYTES];
  logic       done_q;
  act_t       act;
  logic [LEN_W-1:0] exp_len;
  logic       mode_ok, ok;
  meas_cfg_t  cfg_q, cfg_new;
  logic       start_q, mclr_q, lclr_q;

  // command and sub-command capture, cleared once the verdict is taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      sub_q <= '0;
    end else if (done_q) begin
      cmd_q <= '0;
      sub_q <= '0;
    end else if (byte_stb) begin
      if (body_idx == LEN_W'(0)) cmd_q <= in_data;
      if (body_idx == LEN_W'(1)) sub_q <= in_data;
    end
  end

  // payload shadow bytes, one enable per offset
  for (genvar k = 0; k < PAYLOAD_BYTES; k++) begin : g_pay
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pay_q[k] <= '0;
      else if (byte_stb && body_idx == LEN_W'(k + BARE_LEN))
        pay_q[k] <= in_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= pkt_end;
  end

  // pair decode and expected length
  always_comb begin
    act     = ACT_NONE;
    exp_len = LEN_W'(BARE_LEN);
    unique case (cmd_q)
      CMD_IDENT: act = ACT_IDENT;
      CMD_BITLIST: begin
        if (sub_q == SUB_CLEAR) act = ACT_LCLR;
      end
      CMD_MEAS: begin
        unique case (sub_q)
          SUB_STORE: begin
            act     = ACT_STORE;
            exp_len = LEN_W'(STORE_LEN);
          end
          SUB_START: act = ACT_START;
          SUB_CLEAR: act = ACT_MCLR;
          default:   act = ACT_NONE;
        endcase
      end
      default: act = ACT_NONE;
    endcase
  end

  assign mode_ok = (pay_q[2] == 8'h00) || (pay_q[2] == 8'h01);
  assign ok      = (act != ACT_NONE) && (pkt_len == exp_len) &&
                   ((act != ACT_STORE) || mode_ok);

  always_comb begin
    cfg_new.id       = {pay_q[1], pay_q[0]};
    cfg_new.parallel = pay_q[2][0];
    cfg_new.readouts = {pay_q[6],  pay_q[5],  pay_q[4],  pay_q[3]};
    cfg_new.eval_sel = {pay_q[10], pay_q[9],  pay_q[8],  pay_q[7]};
    cfg_new.heatup   = {pay_q[14], pay_q[13], pay_q[12], pay_q[11]};
    cfg_new.cooldown = {pay_q[18], pay_q[17], pay_q[16], pay_q[15]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cfg_q <= '0;
    else if (done_q && ok && act == ACT_STORE)
      cfg_q <= cfg_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      mclr_q  <= 1'b0;
      lclr_q  <= 1'b0;
    end else begin
      start_q <= done_q && ok && (act == ACT_START);
      mclr_q  <= done_q && ok && (act == ACT_MCLR);
      lclr_q  <= done_q && ok && (act == ACT_LCLR);
    end
  end

  assign rsp_load         = done_q;
  assign rsp_bytes[0]     = cmd_q;
  assign rsp_bytes[1]     = sub_q;
  assign rsp_bytes[2]     = ok ? ST_ACK : ST_NACK;
  assign cfg              = cfg_q;
  assign start_pulse      = start_q;
  assign meas_clear_pulse = mclr_q;
  assign list_clear_pulse = lclr_q;

endmodule

// File: rtl/cpp_responder.sv
module cpp_responder
  import cpp_pkg::*;
#(
  localparam int SEL_W = $clog2(REPLY_BYTES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic [REPLY_BYTES-1:0][7:0] load_bytes,
  output logic                        out_valid,
  output logic [7:0]                  out_data,
  input  logic                        out_ready,
  output logic                        done
);

  logic [REPLY_BYTES-1:0][7:0] buf_q;
  logic [SEL_W-1:0]            sel_q, sel_d;
  logic                        busy_q, busy_d;
  logic                        take;

  assign take      = busy_q && out_ready;
  assign done      = take && (sel_q == SEL_W'(REPLY_BYTES - 1));
  assign out_valid = busy_q;
  assign out_data  = buf_q[sel_q];

  always_comb begin
    sel_d  = sel_q;
    busy_d = busy_q;
    if (load) begin
      sel_d  = '0;
      busy_d = 1'b1;
    end else if (done) begin
      sel_d  = '0;
      busy_d = 1'b0;
    end else if (take) begin
      sel_d = sel_q + SEL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    buf_q <= '0;
    else if (load) buf_q <= load_bytes;
  end

endmodule

// File: rtl/cmd_packet_parser.sv
module cmd_packet_parser
  import cpp_pkg::*;
#(
  parameter int HDR_BYTES = 4,
  parameter int SYNC_STAGES = 2,
  localparam int LEN_W = 8 * HDR_BYTES
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  output logic        out_valid,
  output logic [7:0]  out_data,
  input  logic        out_ready,
  output logic [15:0] meas_id,
  output logic        meas_parallel,
  output logic [31:0] meas_readouts,
  output logic [31:0] meas_eval_sel,
  output logic [31:0] meas_heatup,
  output logic [31:0] meas_cooldown,
  output logic        start_pulse,
  output logic        meas_clear_pulse,
  output logic        list_clear_pulse
);

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_core_n;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[SYNC_STAGES-1];

  logic                        byte_stb, pkt_end, rsp_load, rsp_done;
  logic [LEN_W-1:0]            body_idx, pkt_len;
  logic [REPLY_BYTES-1:0][7:0] rsp_bytes;
  meas_cfg_t                   cfg;

  cpp_framer #(.HDR_BYTES(HDR_BYTES)) u_framer (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_ready   (in_ready),
    .reply_done (rsp_done),
    .byte_stb   (byte_stb),
    .body_idx   (body_idx),
    .pkt_len    (pkt_len),
    .pkt_end    (pkt_end)
  );

  cpp_decoder #(.HDR_BYTES(HDR_BYTES)) u_decoder (
    .clk              (clk),
    .rst_n            (rst_core_n),
    .byte_stb         (byte_stb),
    .body_idx         (body_idx),
    .in_data          (in_data),
    .pkt_end          (pkt_end),
    .pkt_len          (pkt_len),
    .rsp_load         (rsp_load),
    .rsp_bytes        (rsp_bytes),
    .cfg              (cfg),
    .start_pulse      (start_pulse),
    .meas_clear_pulse (meas_clear_pulse),
    .list_clear_pulse (list_clear_pulse)
  );

  cpp_responder u_responder (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .load       (rsp_load),
    .load_bytes (rsp_bytes),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_ready  (out_ready),
    .done       (rsp_done)
  );

  assign meas_id       = cfg.id;
  assign meas_parallel = cfg.parallel;
  assign meas_readouts = cfg.readouts;
  assign meas_eval_sel = cfg.eval_sel;
  assign meas_heatup   = cfg.heatup;
  assign meas_cooldown = cfg.cooldown;

endmodule

// File: rtl/cpp_checker.sv
module cpp_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        out_valid,
  input logic [7:0]  out_data,
  input logic        out_ready,
  input logic [15:0] meas_id,
  input logic        meas_parallel,
  input logic [31:0] meas_readouts,
  input logic [31:0] meas_eval_sel,
  input logic [31:0] meas_heatup,
  input logic [31:0] meas_cooldown,
  input logic        start_pulse,
  input logic        meas_clear_pulse,
  input logic        list_clear_pulse
);

  // R3
  reply_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R3
  reply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R6
  start_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

  // R6
  start_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> (out_valid && out_data == 8'h04));

  // R7
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_pulse, meas_clear_pulse, list_clear_pulse}));

  // R7
  lclr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    list_clear_pulse |-> (out_valid && out_data == 8'h03));

  // R5
  cfg_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({meas_id, meas_parallel, meas_readouts, meas_eval_sel,
              meas_heatup, meas_cooldown}) |-> (out_valid && out_data == 8'h04));

endmodule

bind cmd_packet_parser cpp_checker u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .in_ready         (in_ready),
  .out_valid        (out_valid),
  .out_data         (out_data),
  .out_ready        (out_ready),
  .meas_id          (meas_id),
  .meas_parallel    (meas_parallel),
  .meas_readouts    (meas_readouts),
  .meas_eval_sel    (meas_eval_sel),
  .meas_heatup      (meas_heatup),
  .meas_cooldown    (meas_cooldown),
  .start_pulse      (start_pulse),
  .meas_clear_pulse (meas_clear_pulse),
  .list_clear_pulse (list_clear_pulse)
);

// File: tb/cmd_packet_parser_tb.sv
module cmd_packet_parser_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_ready = 1'b0;
  logic [15:0] meas_id;
  logic        meas_parallel;
  logic [31:0] meas_readouts, meas_eval_sel, meas_heatup, meas_cooldown;
  logic        start_pulse, meas_clear_pulse, list_clear_pulse;

  int total = 0;
  int bad = 0;
  int n_start = 0;
  int n_mclr = 0;
  int n_lclr = 0;
  logic [7:0] pb [0:299];

  always #2.5 clk = ~clk;

  cmd_packet_parser u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .meas_id(meas_id), .meas_parallel(meas_parallel),
    .meas_readouts(meas_readouts), .meas_eval_sel(meas_eval_sel),
    .meas_heatup(meas_heatup), .meas_cooldown(meas_cooldown),
    .start_pulse(start_pulse), .meas_clear_pulse(meas_clear_pulse),
    .list_clear_pulse(list_clear_pulse)
  );

  always @(negedge clk) begin
    if (start_pulse)      n_start++;
    if (meas_clear_pulse) n_mclr++;
    if (list_clear_pulse) n_lclr++;
  end

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_byte(input logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_pkt(input logic [31:0] len, input int n);
    for (int i = 0; i < 4; i++) put_byte(len[8*i +: 8]);
    for (int i = 0; i < n; i++) put_byte(pb[i]);
  endtask

  task automatic expect_reply(input logic [7:0] c, input logic [7:0] s, input logic [7:0] st, input string req);
    logic [7:0] got [3];
    out_ready = 1'b1;
    for (int i = 0; i < 3; i++) begin
      while (!out_valid) @(negedge clk);
      got[i] = out_data;
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk({got[0], got[1], got[2]} == {c, s, st}, req,
        {40'd0, got[0], got[1], got[2]}, {40'd0, c, s, st});
  endtask

  task automatic fill_store(input logic [7:0] mode);
    pb[0] = 8'h04; pb[1] = 8'h01;
    pb[2] = 8'hEF; pb[3] = 8'hBE; pb[4] = mode;
    for (int i = 0; i < 16; i++) pb[5 + i] = 8'h10 + 8'(i);
  endtask

  task automatic t_reset();
    chk(in_ready == 1'b1, "R1 in_ready", 64'(in_ready), 64'd1);
    chk(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'd0);
    chk({meas_id, meas_parallel, meas_readouts, meas_eval_sel, meas_heatup, meas_cooldown} == '0,
        "R1 fields", 64'(meas_readouts), 64'd0);
    chk(n_start + n_mclr + n_lclr == 0, "R1 pulses", 64'(n_start + n_mclr + n_lclr), 64'd0);
  endtask

  task automatic t_identify();
    pb[0] = 8'h01; pb[1] = 8'h07;
    send_pkt(32'd2, 2);
    expect_reply(8'h01, 8'h07, 8'h06, "R4 identify");
  endtask

  task automatic t_store_parallel();
    fill_store(8'h01);
    send_pkt(32'd21, 21);
    expect_reply(8'h04, 8'h01, 8'h06, "R5 store ack");
    chk(meas_id == 16'hBEEF, "R5 id", 64'(meas_id), 64'hBEEF);
    chk(meas_readouts == 32'h13121110, "R5 readouts", 64'(meas_readouts), 64'h13121110);
    chk(meas_eval_sel == 32'h17161514, "R5 eval", 64'(meas_eval_sel), 64'h17161514);
    chk(meas_heatup == 32'h1B1A1918, "R5 heatup", 64'(meas_heatup), 64'h1B1A1918);
    chk(meas_cooldown == 32'h1F1E1D1C, "R5 cooldown", 64'(meas_cooldown), 64'h1F1E1D1C);
    chk(meas_parallel == 1'b1, "R11 parallel", 64'(meas_parallel), 64'd1);
  endtask

  task automatic t_store_serial_and_badmode();
    fill_store(8'h00);
    pb[2] = 8'h34; pb[3] = 8'h12;
    send_pkt(32'd21, 21);
    expect_reply(8'h04, 8'h01, 8'h06, "R11 serial ack");
    chk(meas_parallel == 1'b0, "R11 serial", 64'(meas_parallel), 64'd0);
    chk(meas_id == 16'h1234, "R5 id2", 64'(meas_id), 64'h1234);
    fill_store(8'h02);
    send_pkt(32'd21, 21);
    expect_reply(8'h04, 8'h01, 8'h15, "R11 bad mode nack");
    chk(meas_id == 16'h1234 && meas_parallel == 1'b0, "R11 unchanged",
        64'({meas_id, meas_parallel}), 64'({16'h1234, 1'b0}));
  endtask

  task automatic t_start();
    int s0 = n_start;
    pb[0] = 8'h04; pb[1] = 8'h03;
    send_pkt(32'd2, 2);
    expect_reply(8'h04, 8'h03, 8'h06, "R6 start ack");
    chk(n_start == s0 + 1, "R6 one-cycle pulse", 64'(n_start - s0), 64'd1);
  endtask

  task automatic t_clears();
    int m0 = n_mclr;
    int l0 = n_lclr;
    pb[0] = 8'h04; pb[1] = 8'hF0;
    send_pkt(32'd2, 2);
    expect_reply(8'h04, 8'hF0, 8'h06, "R7 meas clear ack");
    chk(n_mclr == m0 + 1 && n_lclr == l0, "R7 meas clear pulse", 64'(n_mclr - m0), 64'd1);
    pb[0] = 8'h03; pb[1] = 8'hF0;
    send_pkt(32'd2, 2);
    expect_reply(8'h03, 8'hF0, 8'h06, "R7 list clear ack");
    chk(n_lclr == l0 + 1 && n_mclr == m0 + 1, "R7 list clear pulse", 64'(n_lclr - l0), 64'd1);
  endtask

  task automatic t_unsupported();
    int p0 = n_start + n_mclr + n_lclr;
    pb[0] = 8'h02; pb[1] = 8'h01; pb[2] = 8'h04; pb[3] = 8'h03; pb[4] = 8'h02; pb[5] = 8'h00;
    send_pkt(32'd6, 6);
    expect_reply(8'h02, 8'h01, 8'h15, "R8 file cmd nack");
    pb[0] = 8'h03; pb[1] = 8'h01; pb[2] = 8'hAA;
    send_pkt(32'd3, 3);
    expect_reply(8'h03, 8'h01, 8'h15, "R8 bitlist add nack");
    chk(n_start + n_mclr + n_lclr == p0, "R8 no pulse", 64'(n_start + n_mclr + n_lclr), 64'(p0));
    chk(meas_id == 16'h1234, "R8 fields unchanged", 64'(meas_id), 64'h1234);
    t_identify();
  endtask

  task automatic t_len_mismatch();
    int s0 = n_start;
    pb[0] = 8'h04; pb[1] = 8'h03; pb[2] = 8'h00;
    send_pkt(32'd3, 3);
    expect_reply(8'h04, 8'h03, 8'h15, "R9 start long nack");
    chk(n_start == s0, "R9 no start", 64'(n_start - s0), 64'd0);
    fill_store(8'h01);
    send_pkt(32'd20, 20);
    expect_reply(8'h04, 8'h01, 8'h15, "R9 short store nack");
    chk(meas_id == 16'h1234 && meas_parallel == 1'b0, "R9 fields unchanged",
        64'(meas_id), 64'h1234);
  endtask

  task automatic t_short();
    send_pkt(32'd0, 0);
    expect_reply(8'h00, 8'h00, 8'h15, "R10 length zero");
    pb[0] = 8'h01;
    send_pkt(32'd1, 1);
    expect_reply(8'h01, 8'h00, 8'h15, "R10 length one");
  endtask

  task automatic t_backpressure();
    pb[0] = 8'h01; pb[1] = 8'h55;
    send_pkt(32'd2, 2);
    while (!out_valid) @(negedge clk);
    repeat (8) @(negedge clk);
    chk(out_valid == 1'b1 && out_data == 8'h01, "R3 held byte", 64'(out_data), 64'h01);
    chk(in_ready == 1'b0, "R3 input stalled", 64'(in_ready), 64'd0);
    expect_reply(8'h01, 8'h55, 8'h06, "R3 reply after stall");
    chk(in_ready == 1'b1, "R3 input resumes", 64'(in_ready), 64'd1);
  endtask

  task automatic t_long_header();
    int s0 = n_start;
    pb[0] = 8'h04; pb[1] = 8'h03;
    for (int i = 2; i < 258; i++) pb[i] = 8'(i);
    send_pkt(32'h0000_0102, 258);
    expect_reply(8'h04, 8'h03, 8'h15, "R2 long packet nack");
    chk(n_start == s0, "R9 long no start", 64'(n_start - s0), 64'd0);
    t_identify();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_identify();
    t_store_parallel();
    t_store_serial_and_badmode();
    t_start();
    t_clears();
    t_unsupported();
    t_len_mismatch();
    t_short();
    t_backpressure();
    t_long_header();
    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule